// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block lets an internal requester read or write an external asynchronous device, such as an SRAM, a flash part or a memory-mapped peripheral, one 16-bit word at a time. The requester presents a word address, byte-lane selects, a direction and, for writes, the data. The block then runs the external cycle in three timed phases: setup, strobe and hold. At the end it returns a one-clock completion pulse and, for reads, the captured word.

The length of each phase is set by a static configuration input, counted in interface clocks. The external device can stretch the strobe phase by holding a ready input low. Chip enable, byte enables and address are held constant for the whole access. The read strobe or the write strobe is asserted only during the strobe phase. The output enable stays asserted across the whole of a read. The data bus is split into separate input and output halves with an output-enable qualifier, so the pad ring can build the bidirectional pin.

Top module: `amc_top`

## Requirements
- R1: An accepted access spends exactly S clocks in setup, then St+W clocks in strobe, then H clocks in hold. S, St and H are the effective counts derived from cfg_setup, cfg_strobe and cfg_hold. W is the number of stall clocks under R3.
- R2: From the first setup clock through the last hold clock, mem_ce_n is 0 and mem_addr equals the request address. mem_be_n equals the bitwise inverse of req_be: bit 0 selects data bits 7:0, bit 1 selects bits 15:8, and 0 means the lane is active. None of these values changes during the access. Outside an access, mem_ce_n is 1 and mem_be_n is all ones.
- R3: mem_rdy is sampled on the rising clock edge that would end the final counted strobe clock. Each such edge that sees mem_rdy = 0 adds one strobe clock. mem_rdy has no effect during setup, during hold, or during earlier strobe clocks.
- R4: On a read (req_write = 0), mem_oe_n is 0 for the whole access, mem_re_n is 0 only during strobe clocks, mem_we_n stays 1 and mem_dout_en stays 0.
- R5: On a write (req_write = 1), mem_we_n is 0 only during strobe clocks. mem_dout equals req_wdata and mem_dout_en is 1 for the whole access. mem_oe_n and mem_re_n stay 1.
- R6: On a read, rsp_rdata takes the value mem_din has at the rising edge that ends the strobe phase, which is the edge at which the read strobe rises. rsp_rdata keeps that value until the next read ends.
- R7: A phase count of 0 is treated as 1 clock, so every phase, including the strobe, lasts at least one clock.
- R8: req_ready is 1 only while no access is in progress. A request is accepted only on an edge where req_ready is 1. A req_valid presented while an access is running is ignored and does not start a later access.
- R9: rsp_done is 1 for exactly one clock, the clock immediately after the last hold clock. In that clock mem_ce_n is already 1 and req_ready is 1.
- R10: While rst_n is 0, mem_ce_n, mem_oe_n, mem_re_n and mem_we_n are 1, mem_dout_en and rsp_done are 0, and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| cfg_setup | input | CW | Setup phase length in clocks (0 means 1) |
| cfg_strobe | input | CW | Minimum strobe phase length in clocks (0 means 1) |
| cfg_hold | input | CW | Hold phase length in clocks (0 means 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | DW/8 | Byte lanes to enable, active high |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW | Last word read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_addr | output | AW | External word address |
| mem_dout | output | DW | Data driven toward the device |
| mem_dout_en | output | 1 | Output driver enable for mem_dout |
| mem_din | input | DW | Data returned by the device |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_rdy | input | 1 | Device ready, stretches the strobe when low |

## Verification
The bench counts every phase clock by clock. A counter that is off by one, or that ignores the zero-means-one rule, shows up as a wrong setup, strobe or hold length; a zero count would otherwise wrap to a very long phase. Ready is held low before the final strobe clock and during setup and hold. A design that samples ready at the wrong time therefore stretches when it should not, or fails to stretch when it should. Read data changes on every strobe clock, so capturing one clock early or late returns the wrong word. A request poked in the middle of an access catches a design that takes requests while busy, which would show as an address change or a second cycle.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // effective number of clocks for a programmed phase count
  function automatic int unsigned phase_clocks(input int unsigned prog);
    return (prog == 0) ? 1 : prog;
  endfunction

endpackage

// File: rtl/amc_phase_seq.sv
module amc_phase_seq
  import amc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic          mem_rdy,
  output phase_t        phase,
  output logic          strobe_end,
  output logic          access_end
);

  logic [CW-1:0] cnt;
  logic          last_clk;

  function automatic logic [CW-1:0] load_val(input logic [CW-1:0] prog);
    return CW'(phase_clocks(32'(prog)) - 1);
  endfunction

  assign last_clk   = (cnt == '0);
  assign strobe_end = (phase == PH_STROBE) && last_clk && mem_rdy;
  assign access_end = (phase == PH_HOLD) && last_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_SETUP;
            cnt   <= load_val(cfg_setup);
          end
        end
        PH_SETUP: begin
          if (last_clk) begin
            phase <= PH_STROBE;
            cnt   <= load_val(cfg_strobe);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (!last_clk) begin
            cnt <= cnt - 1'b1;
          end else if (mem_rdy) begin
            phase <= PH_HOLD;
            cnt   <= load_val(cfg_hold);
          end
        end
        PH_HOLD: begin
          if (last_clk) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/amc_bus_drv.sv
module amc_bus_drv
  import amc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  input  phase_t        phase,
  input  logic          strobe_end,
  input  logic [DW-1:0] mem_din,
  output logic          mem_ce_n,
  output logic [BW-1:0] mem_be_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  output logic          mem_oe_n,
  output logic          mem_re_n,
  output logic          mem_we_n,
  output logic [DW-1:0] rd_data
);

  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] be_q;
  logic [DW-1:0] wdata_q;
  logic          busy;
  logic          in_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (strobe_end && !wr_q) begin
      rd_data <= mem_din;
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign in_strobe = (phase == PH_STROBE);

  always_comb begin
    mem_ce_n    = !busy;
    mem_be_n    = busy ? ~be_q : '1;
    mem_addr    = addr_q;
    mem_dout    = wdata_q;
    mem_dout_en = busy && wr_q;
    mem_oe_n    = !(busy && !wr_q);
    mem_re_n    = !(in_strobe && !wr_q);
    mem_we_n    = !(in_strobe && wr_q);
  end

endmodule

// File: rtl/amc_top.sv
module amc_top
  import amc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 4,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic [BW-1:0] mem_be_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din,
  output logic          mem_oe_n,
  output logic          mem_re_n,
  output logic          mem_we_n,
  input  logic          mem_rdy
);

  phase_t phase;
  logic   start;
  logic   strobe_end;
  logic   access_end;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  amc_phase_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_hold   (cfg_hold),
    .mem_rdy    (mem_rdy),
    .phase      (phase),
    .strobe_end (strobe_end),
    .access_end (access_end)
  );

  amc_bus_drv #(.AW(AW), .DW(DW)) u_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .phase       (phase),
    .strobe_end  (strobe_end),
    .mem_din     (mem_din),
    .mem_ce_n    (mem_ce_n),
    .mem_be_n    (mem_be_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mem_oe_n    (mem_oe_n),
    .mem_re_n    (mem_re_n),
    .mem_we_n    (mem_we_n),
    .rd_data     (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_done <= 1'b0;
    else        rsp_done <= access_end;
  end

endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_re_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [BW-1:0] mem_be_n,
  input logic [DW-1:0] mem_dout,
  input logic          mem_dout_en,
  input logic          mem_rdy,
  input logic [DW-1:0] mem_din,
  input logic          rsp_done,
  input logic [DW-1:0] rsp_rdata,
  input logic          req_ready
);

  // R2: address and lanes hold still while chip enable stays low
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  // R4, R5: a strobe only inside chip enable, never both strobes at once
  a_r4_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_re_n || !mem_we_n) |-> !mem_ce_n);
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_re_n && !mem_we_n));

  // R4: read strobe only while output enable is asserted
  a_r4_re_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re_n |-> !mem_oe_n);

  // R5: write data held while driven
  a_r5_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

  // R3: a strobe ends only on an edge that saw ready high
  a_r3_end_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_re_n) || $rose(mem_we_n)) |-> $past(mem_rdy));

  // R6: read word is the one present at the closing strobe edge
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re_n) |-> (rsp_rdata == $past(mem_din)));

  // R9: done is a single clock and comes with the bus released
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_ce_n && req_ready));

endmodule

bind amc_top amc_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_amc_top.sv
`timescale 1ns/1ps
module tb_amc_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_dout_en, mem_oe_n, mem_re_n, mem_we_n;
  logic [BW-1:0] mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din = '0;
  logic          mem_rdy = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  amc_top #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_re_n && mem_we_n, "R10", {mem_ce_n, mem_oe_n, mem_re_n, mem_we_n}, 15);
    check(!mem_dout_en && !rsp_done && req_ready, "R10", {mem_dout_en, rsp_done, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one access; w = stall clocks, rdy_out = ready level outside strobe, poke = busy request
  task automatic t_access(input bit wr, input int addr, input int be, input int wdata,
                          input int s, input int st, input int h, input int w,
                          input bit rdy_out, input bit poke, input int base);
    int es, est, eh, n_setup, n_strobe, n_hold, cyc, sidx;
    bit seen_strobe, bad_bus, bad_dir, bad_ready, got_done;
    es = eff(s); est = eff(st); eh = eff(h);
    n_setup = 0; n_strobe = 0; n_hold = 0; cyc = 0;
    seen_strobe = 0; bad_bus = 0; bad_dir = 0; bad_ready = 0; got_done = 0;
    cfg_setup = CW'(s); cfg_strobe = CW'(st); cfg_hold = CW'(h);
    req_write = wr; req_addr = AW'(addr); req_be = BW'(be); req_wdata = DW'(wdata);
    mem_rdy = rdy_out; mem_din = 16'hDEAD;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (rsp_done) begin got_done = 1; break; end
      cyc++;
      if (mem_ce_n) bad_bus = 1;
      if (mem_addr != AW'(addr) || mem_be_n != ~BW'(be)) bad_bus = 1;
      if (req_ready) bad_ready = 1;
      if (wr) begin
        if (!mem_oe_n || !mem_re_n || !mem_dout_en || mem_dout != DW'(wdata)) bad_dir = 1;
      end else begin
        if (mem_oe_n || !mem_we_n || mem_dout_en) bad_dir = 1;
      end
      if (!mem_re_n || !mem_we_n) begin
        seen_strobe = 1;
        n_strobe++;
        sidx = n_strobe - 1;
        mem_rdy = (sidx >= est + w - 1);
        mem_din = DW'(base + sidx);
      end else begin
        if (seen_strobe) n_hold++; else n_setup++;
        mem_rdy = rdy_out;
      end
      if (poke && cyc == 2) begin
        req_valid = 1'b1; req_addr = AW'(addr ^ 1);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(got_done, "R9", got_done, 1);
    check(n_setup == es, "R1", n_setup, es);
    check(n_strobe == est + w, (w != 0) ? "R3" : (st == 0 ? "R7" : "R1"), n_strobe, est + w);
    check(n_hold == eh, (h == 0) ? "R7" : "R1", n_hold, eh);
    check(!bad_bus, "R2", bad_bus, 0);
    check(!bad_dir, wr ? "R5" : "R4", bad_dir, 0);
    check(!bad_ready, "R8", bad_ready, 0);
    check(mem_ce_n && req_ready, "R9", {mem_ce_n, req_ready}, 3);
    if (!wr) check(rsp_rdata == DW'(base + est + w - 1), "R6", rsp_rdata, base + est + w - 1);
    @(negedge clk);
    check(!rsp_done, "R9", rsp_done, 0);
    if (poke) begin
      repeat (3) begin
        check(mem_ce_n, "R8", mem_ce_n, 1);
        @(negedge clk);
      end
    end
    if (!wr) check(rsp_rdata == DW'(base + est + w - 1), "R6", rsp_rdata, base + est + w - 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_access(0, 'h12345, 3, 0, 2, 3, 2, 0, 1'b0, 1'b0, 'h100);
    t_access(1, 'h00ABC, 3, 'hBEEF, 2, 3, 2, 2, 1'b0, 1'b0, 0);
    t_access(0, 'h00007, 1, 0, 0, 0, 0, 0, 1'b1, 1'b0, 'h200);
    t_access(1, 'hFFFFF, 1, 'h5A5A, 1, 1, 1, 0, 1'b1, 1'b0, 0);
    t_access(0, 'h0C0C0, 2, 0, 3, 1, 4, 3, 1'b0, 1'b1, 'h300);
    t_access(1, 'h00300, 2, 'h1234, 0, 4, 3, 1, 1'b0, 1'b1, 0);
    t_access(0, 'h00001, 3, 0, 15, 15, 15, 0, 1'b1, 1'b0, 'h400);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule